// File: doc/BRIEF.md
# CEC Transmit Retry and Status Controller

This block is the transmit-side sequencer of a consumer-electronics-control bus controller. It sits above the bit-level line driver. Software loads a frame of up to sixteen bytes, a byte count and a retry limit through a simple register write port. It then sets a start bit. The block issues transmit attempts on an abstract attempt interface, and each attempt returns one of four results: success, arbitration lost, no acknowledge, or low drive.

Retries run entirely in hardware. Negative-acknowledge failures and low-drive failures are counted in two separate 4-bit fields of one status byte. A transfer ends in one of three ways: success, arbitration lost, or running out of retries. Each ending sets its own sticky, write-1-to-clear flag. Each flag has its own enable bit, and the enabled flags are combined into one interrupt line. The block also gives an encoded cause, which names the pending flag that software should service first.

Register offsets: frame bytes at 0..15 (header at 0), byte count at 16, retry limit at 17 bits [6:4], transmit enable at 18 bit 0, flag status at 19, flag enable at 20, failure counts at 21. In both the flag status and the flag enable registers, bit 5 is ready, bit 4 is arbitration lost and bit 3 is retry timeout. Attempt results are coded 0 success, 1 arbitration lost, 2 no acknowledge, 3 low drive.

Top module: `cec_tx_ctrl`

## Requirements
- R1: After reset, every readable register is 0, `irq` is 0, `tx_cause` is 0 and `att_start` is 0.
- R2: A write of 1 to bit 0 of offset 18 while idle makes `att_start` high for exactly one cycle, in the cycle after the write. Offset 18 bit 0 reads 1 from that cycle until the transfer ends. A write to offset 18 while a transfer is running is ignored.
- R3: Bytes written at offsets 0..15 appear on `att_frame` (offset k at bits [8k+7:8k]), and the byte count written at offset 16 appears on `att_len`.
- R4: A success result sets the ready flag (offset 19 bit 5) and clears the transmit-enable bit. No further attempt is issued.
- R5: An arbitration-lost result sets flag bit 4 and ends the transfer at once. No retry is made, whatever the failure count.
- R6: Each no-acknowledge result adds 1 to offset 21 bits [3:0]. Each low-drive result adds 1 to offset 21 bits [7:4]. Both counts saturate at 15.
- R7: With retry limit L (a value of 0 is treated as 1), the transfer ends after L+1 failed attempts and sets the retry-timeout flag (bit 3). Before that point, each failure causes a new attempt.
- R8: Both failure counts clear to 0 when a new transfer starts.
- R9: Writing 1 to a bit of offset 19 clears that flag. If a flag is set in the same cycle as its clear, the set wins.
- R10: `irq` is high exactly when some flag in offset 19 is set and its enable bit in offset 20 is also set.
- R11: `tx_cause` gives the highest-priority pending flag: 1 for arbitration lost, then 2 for retry timeout, then 3 for ready, and 0 when no flag is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 5 | Register write offset |
| wr_data | input | 8 | Register write data |
| rd_addr | input | 5 | Register read offset |
| rd_data | output | 8 | Register read data (combinational) |
| att_start | output | 1 | One-cycle request for a transmit attempt |
| att_done | input | 1 | Attempt finished, result valid |
| att_result | input | 2 | Attempt result code |
| att_frame | output | 128 | Frame bytes, header in the lowest byte |
| att_len | output | 5 | Frame byte count |
| irq | output | 1 | Combined enabled-flag interrupt |
| tx_cause | output | 2 | Encoded highest-priority pending flag |

## Verification
The result of a final attempt and a software write-1-to-clear of the flag status can land in the same clock cycle. The bench provokes this by driving `att_done` and a clear write of all three flags together on the last attempt of a transfer. It then judges that the flag set by that ending survives, while the other flags are cleared. Random flag clears between transfers let several flags build up, so the priority encoding is judged against a bench model of the pending flags.

// File: rtl/cec_tx_pkg.sv
package cec_tx_pkg;

    localparam int FRAME_BYTES = 16;
    localparam int LEN_W       = $clog2(FRAME_BYTES + 1);
    localparam int NUM_REGS    = FRAME_BYTES + 6;
    localparam int ADDR_W      = $clog2(NUM_REGS);
    localparam int CNT_W       = 4;
    localparam int LIM_W       = 3;
    localparam int LIM_LSB     = 4;
    localparam int FLAG_LSB    = 3;

    localparam logic [ADDR_W-1:0] A_LEN   = ADDR_W'(FRAME_BYTES);
    localparam logic [ADDR_W-1:0] A_RETRY = ADDR_W'(FRAME_BYTES + 1);
    localparam logic [ADDR_W-1:0] A_EN    = ADDR_W'(FRAME_BYTES + 2);
    localparam logic [ADDR_W-1:0] A_FLAGS = ADDR_W'(FRAME_BYTES + 3);
    localparam logic [ADDR_W-1:0] A_FLEN  = ADDR_W'(FRAME_BYTES + 4);
    localparam logic [ADDR_W-1:0] A_FAIL  = ADDR_W'(FRAME_BYTES + 5);

    typedef enum logic [1:0] {
        RES_OK     = 2'd0,
        RES_ARB    = 2'd1,
        RES_NACK   = 2'd2,
        RES_LOWDRV = 2'd3
    } att_res_e;

    typedef enum logic [1:0] {
        SQ_IDLE   = 2'd0,
        SQ_LAUNCH = 2'd1,
        SQ_WAIT   = 2'd2
    } seq_st_e;

    // field order matches status bits 5,4,3
    typedef struct packed {
        logic ready;
        logic arb;
        logic timeout;
    } tx_flags_t;

    function automatic logic [CNT_W-1:0] sat_inc(input logic [CNT_W-1:0] v);
        return (v == {CNT_W{1'b1}}) ? v : v + 1'b1;
    endfunction

    function automatic logic [1:0] cause_of(input tx_flags_t f);
        if (f.arb)          return 2'd1;
        else if (f.timeout) return 2'd2;
        else if (f.ready)   return 2'd3;
        else                return 2'd0;
    endfunction

endpackage

// File: rtl/cec_tx_regs.sv
module cec_tx_regs
    import cec_tx_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     wr_en,
    input  logic [ADDR_W-1:0]        wr_addr,
    input  logic [7:0]               wr_data,
    output logic [FRAME_BYTES*8-1:0] frame,
    output logic [LEN_W-1:0]         len,
    output logic [LIM_W-1:0]         limit,
    output tx_flags_t                flag_en
);

    generate
        for (genvar k = 0; k < FRAME_BYTES; k++) begin : g_byte
            always_ff @(posedge clk) begin
                if (rst)
                    frame[8*k +: 8] <= '0;
                else if (wr_en && wr_addr == ADDR_W'(k))
                    frame[8*k +: 8] <= wr_data;
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            len     <= '0;
            limit   <= '0;
            flag_en <= '0;
        end else if (wr_en) begin
            if (wr_addr == A_LEN)   len     <= wr_data[LEN_W-1:0];
            if (wr_addr == A_RETRY) limit   <= wr_data[LIM_LSB +: LIM_W];
            if (wr_addr == A_FLEN)  flag_en <= wr_data[FLAG_LSB +: 3];
        end
    end

endmodule

// File: rtl/cec_tx_seq.sv
module cec_tx_seq
    import cec_tx_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             start_req,
    input  logic [LIM_W-1:0] limit,
    input  logic             att_done,
    input  logic [1:0]       att_result,
    output logic             att_start,
    output logic             busy,
    output logic [7:0]       fail_stat,
    output tx_flags_t        ev
);

    seq_st_e          st_q, st_d;
    logic [CNT_W-1:0] nack_q, low_q, tries_q;
    logic [CNT_W-1:0] tries_nxt;
    logic [LIM_W-1:0] eff_lim;
    logic             fail_now;

    assign eff_lim   = (limit == '0) ? LIM_W'(1) : limit;
    assign tries_nxt = tries_q + 1'b1;
    assign fail_now  = (st_q == SQ_WAIT) && att_done &&
                       (att_result == RES_NACK || att_result == RES_LOWDRV);

    always_comb begin
        st_d = st_q;
        ev   = '0;
        unique case (st_q)
            SQ_IDLE:   if (start_req) st_d = SQ_LAUNCH;
            SQ_LAUNCH: st_d = SQ_WAIT;
            SQ_WAIT: begin
                if (att_done) begin
                    if (att_result == RES_OK) begin
                        ev.ready = 1'b1;
                        st_d     = SQ_IDLE;
                    end else if (att_result == RES_ARB) begin
                        ev.arb = 1'b1;
                        st_d   = SQ_IDLE;
                    end else if (tries_nxt > CNT_W'(eff_lim)) begin
                        ev.timeout = 1'b1;
                        st_d       = SQ_IDLE;
                    end else begin
                        st_d = SQ_LAUNCH;
                    end
                end
            end
            default: st_d = SQ_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q    <= SQ_IDLE;
            nack_q  <= '0;
            low_q   <= '0;
            tries_q <= '0;
        end else begin
            st_q <= st_d;
            if (st_q == SQ_IDLE && start_req) begin
                nack_q  <= '0;
                low_q   <= '0;
                tries_q <= '0;
            end else if (fail_now) begin
                tries_q <= tries_nxt;
                if (att_result == RES_NACK) nack_q <= sat_inc(nack_q);
                else                        low_q  <= sat_inc(low_q);
            end
        end
    end

    assign att_start = (st_q == SQ_LAUNCH);
    assign busy      = (st_q != SQ_IDLE);
    assign fail_stat = {low_q, nack_q};

endmodule

// File: rtl/cec_tx_irq.sv
module cec_tx_irq
    import cec_tx_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  tx_flags_t ev,
    input  tx_flags_t clr,
    input  tx_flags_t flag_en,
    output tx_flags_t flags,
    output logic      irq,
    output logic [1:0] cause
);

    always_ff @(posedge clk) begin
        if (rst) flags <= '0;
        else     flags <= (flags & ~clr) | ev;
    end

    assign irq   = |(flags & flag_en);
    assign cause = cause_of(flags);

endmodule

// File: rtl/cec_tx_ctrl.sv
module cec_tx_ctrl
    import cec_tx_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     wr_en,
    input  logic [ADDR_W-1:0]        wr_addr,
    input  logic [7:0]               wr_data,
    input  logic [ADDR_W-1:0]        rd_addr,
    output logic [7:0]               rd_data,
    output logic                     att_start,
    input  logic                     att_done,
    input  logic [1:0]               att_result,
    output logic [FRAME_BYTES*8-1:0] att_frame,
    output logic [LEN_W-1:0]         att_len,
    output logic                     irq,
    output logic [1:0]               tx_cause
);

    logic             busy;
    logic             start_req;
    logic [LIM_W-1:0] limit;
    logic [7:0]       fail_stat;
    tx_flags_t        ev, clr, flags, flag_en;

    assign start_req = wr_en && (wr_addr == A_EN) && wr_data[0] && !busy;
    assign clr       = (wr_en && wr_addr == A_FLAGS) ? tx_flags_t'(wr_data[FLAG_LSB +: 3]) : '0;

    cec_tx_regs u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .frame   (att_frame),
        .len     (att_len),
        .limit   (limit),
        .flag_en (flag_en)
    );

    cec_tx_seq u_seq (
        .clk        (clk),
        .rst        (rst),
        .start_req  (start_req),
        .limit      (limit),
        .att_done   (att_done),
        .att_result (att_result),
        .att_start  (att_start),
        .busy       (busy),
        .fail_stat  (fail_stat),
        .ev         (ev)
    );

    cec_tx_irq u_irq (
        .clk     (clk),
        .rst     (rst),
        .ev      (ev),
        .clr     (clr),
        .flag_en (flag_en),
        .flags   (flags),
        .irq     (irq),
        .cause   (tx_cause)
    );

    always_comb begin
        rd_data = '0;
        if (rd_addr < A_LEN) begin
            rd_data = att_frame[8*rd_addr +: 8];
        end else begin
            case (rd_addr)
                A_LEN:   rd_data = 8'(att_len);
                A_RETRY: rd_data[LIM_LSB +: LIM_W] = limit;
                A_EN:    rd_data[0] = busy;
                A_FLAGS: rd_data[FLAG_LSB +: 3] = flags;
                A_FLEN:  rd_data[FLAG_LSB +: 3] = flag_en;
                A_FAIL:  rd_data = fail_stat;
                default: rd_data = '0;
            endcase
        end
    end

endmodule

// File: rtl/cec_tx_ctrl_chk.sv
module cec_tx_ctrl_chk
    import cec_tx_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic       start_req,
    input logic       att_start,
    input logic       att_done,
    input logic [1:0] att_result,
    input logic       busy,
    input tx_flags_t  flags,
    input logic [7:0] fail_stat,
    input logic [1:0] tx_cause
);

    assert_start_pulse_R2: assert property (@(posedge clk) disable iff (rst)
        att_start |=> !att_start);

    assert_start_follows_R2: assert property (@(posedge clk) disable iff (rst)
        start_req |=> att_start);

    assert_ready_source_R4: assert property (@(posedge clk) disable iff (rst)
        $rose(flags.ready) |-> $past(att_done && att_result == RES_OK));

    assert_arb_no_retry_R5: assert property (@(posedge clk) disable iff (rst)
        (busy && !att_start && att_done && att_result == RES_ARB) |=> (!busy && !att_start));

    assert_counts_cleared_R8: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> (fail_stat == 8'h00));

    assert_arb_first_R11: assert property (@(posedge clk) disable iff (rst)
        flags.arb |-> (tx_cause == 2'd1));

endmodule

bind cec_tx_ctrl cec_tx_ctrl_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .start_req  (start_req),
    .att_start  (att_start),
    .att_done   (att_done),
    .att_result (att_result),
    .busy       (busy),
    .flags      (flags),
    .fail_stat  (fail_stat),
    .tx_cause   (tx_cause)
);

// File: tb/tb_cec_tx_ctrl.sv
module tb_cec_tx_ctrl;
    import cec_tx_pkg::*;

    localparam int CLK_PERIOD = 10;

    logic                     clk = 1'b0;
    logic                     rst = 1'b1;
    logic                     wr_en = 1'b0;
    logic [ADDR_W-1:0]        wr_addr = '0;
    logic [7:0]               wr_data = '0;
    logic [ADDR_W-1:0]        rd_addr = '0;
    logic [7:0]               rd_data;
    logic                     att_start;
    logic                     att_done = 1'b0;
    logic [1:0]               att_result = '0;
    logic [FRAME_BYTES*8-1:0] att_frame;
    logic [LEN_W-1:0]         att_len;
    logic                     irq;
    logic [1:0]               tx_cause;

    int checks = 0;
    int errors = 0;
    bit done_flag = 0;
    logic [2:0] m_flags = '0;   // {ready, arb, timeout}
    logic [2:0] m_en    = '0;

    cec_tx_ctrl dut (.*);

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [ADDR_W-1:0] a, input logic [7:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [ADDR_W-1:0] a, output logic [7:0] d);
        rd_addr = a;
        #1;
        d = rd_data;
    endtask

    function automatic logic [1:0] exp_cause(input logic [2:0] f);
        if (f[1])      return 2'd1;
        else if (f[0]) return 2'd2;
        else if (f[2]) return 2'd3;
        else           return 2'd0;
    endfunction

    task automatic check_flags(input string req);
        logic [7:0] d;
        rd(A_FLAGS, d);
        chk(d == {2'b00, m_flags, 3'b000}, req, d, {2'b00, m_flags, 3'b000});
        chk(irq == |(m_flags & m_en), "R10", irq, |(m_flags & m_en));
        chk(tx_cause == exp_cause(m_flags), "R11", tx_cause, exp_cause(m_flags));
    endtask

    // runs one transfer; res holds the attempt results in order
    task automatic run_tx(input int lim, input logic [1:0] res [9], input bit clr_same);
        int eff, n, nk, lw, g;
        logic [2:0] ev;
        logic [7:0] d;
        eff = (lim == 0) ? 1 : lim;
        n = 0; nk = 0; lw = 0; ev = '0;
        for (int i = 0; i < 9; i++) begin
            n++;
            if (res[i] == RES_OK)  begin ev = 3'b100; break; end
            if (res[i] == RES_ARB) begin ev = 3'b010; break; end
            if (res[i] == RES_NACK) nk++; else lw++;
            if (nk + lw > eff) begin ev = 3'b001; break; end
        end
        wr(A_RETRY, 8'(lim << LIM_LSB));
        wr(A_EN, 8'h01);
        chk(att_start == 1'b1, "R2 start pulse", att_start, 1);
        rd(A_EN, d);
        chk(d[0] == 1'b1, "R2 enable readback", d[0], 1);
        for (int i = 0; i < n; i++) begin
            g = 0;
            while (!att_start && g < 20) begin @(negedge clk); g++; end
            if (i > 0) chk(att_start == 1'b1, "R7 retry issued", att_start, 1);
            @(negedge clk);
            if (i == 0) chk(att_start == 1'b0, "R2 single pulse", att_start, 0);
            if (i == 0) begin
                wr(A_EN, 8'h01);   // ignored while busy
                chk(att_start == 1'b0, "R2 write while busy", att_start, 0);
            end
            repeat ($urandom_range(0, 2)) @(negedge clk);
            att_done = 1'b1; att_result = res[i];
            if (i == n - 1 && clr_same) begin
                wr_en = 1'b1; wr_addr = A_FLAGS; wr_data = 8'h38;
            end
            @(negedge clk);
            att_done = 1'b0; wr_en = 1'b0;
        end
        if (clr_same) m_flags = '0;
        m_flags = m_flags | ev;
        rd(A_EN, d);
        chk(d[0] == 1'b0, "R4 enable self-clear", d[0], 0);
        rd(A_FAIL, d);
        chk(d[3:0] == 4'(nk), "R6 nack count", d[3:0], nk);
        chk(d[7:4] == 4'(lw), "R6 low-drive count", d[7:4], lw);
        g = 0;
        repeat (3) begin
            if (att_start) g++;
            @(negedge clk);
        end
        if (ev == 3'b010)      chk(g == 0, "R5 no retry after arb", g, 0);
        else if (ev == 3'b001) chk(g == 0, "R7 stop after limit", g, 0);
        else                   chk(g == 0, "R4 no attempt after success", g, 0);
        check_flags(clr_same ? "R9 set wins" : "R4/R5/R7 flag");
    endtask

    initial begin
        logic [7:0] d;
        logic [1:0] res [9];
        logic [7:0] fb [FRAME_BYTES];
        void'($urandom(32'h5eed_cec1));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        for (int a = 0; a < NUM_REGS; a++) begin
            rd(ADDR_W'(a), d);
            chk(d == 8'h00, "R1 register reset", d, 0);
        end
        chk(irq == 1'b0 && att_start == 1'b0 && tx_cause == 2'd0, "R1 outputs", {irq, att_start, tx_cause}, 0);

        // R3 frame and length
        for (int k = 0; k < FRAME_BYTES; k++) begin
            fb[k] = 8'($urandom);
            wr(ADDR_W'(k), fb[k]);
        end
        wr(A_LEN, 8'(FRAME_BYTES));
        for (int k = 0; k < FRAME_BYTES; k++)
            chk(att_frame[8*k +: 8] == fb[k], "R3 frame byte", att_frame[8*k +: 8], fb[k]);
        chk(att_len == LEN_W'(FRAME_BYTES), "R3 length", att_len, FRAME_BYTES);

        m_en = 3'b111;
        wr(A_FLEN, 8'h38);

        // directed: success first try
        res = '{RES_OK, RES_OK, RES_OK, RES_OK, RES_OK, RES_OK, RES_OK, RES_OK, RES_OK};
        run_tx(3, res, 1'b0);
        // directed: arb lost after one nack
        res = '{RES_NACK, RES_ARB, RES_OK, RES_OK, RES_OK, RES_OK, RES_OK, RES_OK, RES_OK};
        run_tx(3, res, 1'b0);
        // directed: limit 0 acts as 1 (two failures)
        res = '{RES_NACK, RES_LOWDRV, RES_OK, RES_OK, RES_OK, RES_OK, RES_OK, RES_OK, RES_OK};
        run_tx(0, res, 1'b0);
        // directed: limit 7, all nack -> 8 counted; R8 counts restart from 0
        res = '{RES_NACK, RES_NACK, RES_NACK, RES_NACK, RES_NACK, RES_NACK, RES_NACK, RES_NACK, RES_NACK};
        run_tx(7, res, 1'b0);
        res = '{RES_LOWDRV, RES_OK, RES_OK, RES_OK, RES_OK, RES_OK, RES_OK, RES_OK, RES_OK};
        run_tx(2, res, 1'b0);   // R8: nack field must read 0 here
        // R9: final result and clear in the same cycle
        res = '{RES_ARB, RES_OK, RES_OK, RES_OK, RES_OK, RES_OK, RES_OK, RES_OK, RES_OK};
        run_tx(1, res, 1'b1);

        // random transfers
        for (int t = 0; t < 60; t++) begin
            for (int i = 0; i < 9; i++) begin
                int p;
                p = $urandom_range(0, 99);
                res[i] = (p < 20) ? RES_OK : (p < 28) ? RES_ARB : (p < 64) ? RES_NACK : RES_LOWDRV;
            end
            if ($urandom_range(0, 3) == 0) begin
                logic [2:0] c;
                c = 3'($urandom);
                wr(A_FLAGS, {2'b00, c, 3'b000});
                m_flags = m_flags & ~c;
                check_flags("R9 clear");
            end
            if ($urandom_range(0, 3) == 0) begin
                m_en = 3'($urandom);
                wr(A_FLEN, {2'b00, m_en, 3'b000});
                check_flags("R10 enable");
            end
            run_tx($urandom_range(0, 7), res, ($urandom_range(0, 7) == 0));
        end

        done_flag = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done_flag) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule